// File: doc/BRIEF.md
# Speculative Result Rename Pools

This block holds the results of instructions that have executed but not yet completed, so the architected register files only ever see values in program order. It keeps five independent pools. The integer pool and the floating-point pool have six entries each, and there are three one-entry pools for the condition, link and count registers. Each integer and floating-point pool also owns its 32-entry architected file, and each one-entry pool owns a single architected register.

At dispatch, an instruction asks its pool for an entry and gets a tag back in the same cycle. Execution units return results by tag, which marks the entry ready. Waiting consumers look up a tag to learn whether the operand has arrived and to read its value. A result being written in the same cycle reaches the lookup directly. When the completion logic retires the oldest instruction, the head entry's value is copied into the architected register named at allocation, and the entry is freed. A squash discards every entry that has not been retired.

Each pool is a ring with a head pointer and a tail pointer. Allocation takes entries at the tail in order, and retirement frees them at the head. A flush pulls the tail back to the head.

Top module: `rename_pool_top`

## Requirements
- R1: After reset every pool is empty: no lookup reports ready, commit requests are not honoured, and every architected register reads zero.
- R2: The integer and floating-point pools each hold at most six live entries, and each special pool holds one. A request beyond the free count is refused (grant low) until an entry is freed. A free count is the registered value, so an entry freed by a commit can be granted again only from the next cycle.
- R3: The integer and floating-point pools take two allocation requests per cycle, slot 0 being older than slot 1. Tags are handed out consecutively from the tail, skipping slots that do not request, and wrap from 5 to 0. Slot 1 is never granted while slot 0 is requesting and refused.
- R4: A result write to a live tag makes lookups of that tag report ready with the written value. This holds in the cycle of the write (bypass) and in every later cycle until the entry is freed.
- R5: A freshly allocated entry is not ready until its result is written.
- R6: A commit request retires the head entry only if the pool is non-empty and the head entry is ready; commit_done reports this in the same cycle. The head value is then written into the architected register given at allocation, visible from the next cycle. In any other case the commit has no effect.
- R7: A flush discards all live entries. Lookups of discarded tags report not ready, the architected files are unchanged, and allocation requests in the flush cycle are refused. The next allocation receives the tag at the head.
- R8: A commit that is honoured in the same cycle as a flush is still carried out, and the next allocation starts after the retired entry.
- R9: A result write to a tag that is not live, including tags 6 and 7, changes nothing.
- R10: The three special pools work independently of each other and of the other pools, in the bit order condition (0), link (1), count (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Squash all unretired entries in every pool |
| gpr_alloc_req | input | 2 | Integer allocation requests, bit 0 oldest |
| gpr_alloc_dst | input | 2x5 | Architected destination per slot |
| gpr_alloc_gnt | output | 2 | Integer allocation granted |
| gpr_alloc_tag | output | 2x3 | Tag given per slot |
| gpr_wb_vld | input | 1 | Integer result write |
| gpr_wb_tag | input | 3 | Tag of the integer result |
| gpr_wb_data | input | 32 | Integer result value |
| gpr_lk_tag | input | 2x3 | Integer operand lookup tags |
| gpr_lk_rdy | output | 2 | Lookup operand available |
| gpr_lk_data | output | 2x32 | Lookup operand value |
| gpr_commit_req | input | 1 | Retire the oldest integer entry |
| gpr_commit_done | output | 1 | Integer retirement performed |
| gpr_arch_idx | input | 5 | Integer architected read index |
| gpr_arch_data | output | 32 | Integer architected read value |
| fpr_alloc_req | input | 2 | Floating-point allocation requests |
| fpr_alloc_dst | input | 2x5 | Architected destination per slot |
| fpr_alloc_gnt | output | 2 | Floating-point allocation granted |
| fpr_alloc_tag | output | 2x3 | Tag given per slot |
| fpr_wb_vld | input | 1 | Floating-point result write |
| fpr_wb_tag | input | 3 | Tag of the floating-point result |
| fpr_wb_data | input | 64 | Floating-point result value |
| fpr_lk_tag | input | 2x3 | Floating-point lookup tags |
| fpr_lk_rdy | output | 2 | Lookup operand available |
| fpr_lk_data | output | 2x64 | Lookup operand value |
| fpr_commit_req | input | 1 | Retire the oldest floating-point entry |
| fpr_commit_done | output | 1 | Floating-point retirement performed |
| fpr_arch_idx | input | 5 | Floating-point architected read index |
| fpr_arch_data | output | 64 | Floating-point architected read value |
| spr_alloc_req | input | 3 | Special pool allocation requests |
| spr_alloc_gnt | output | 3 | Special pool grants |
| spr_wb_vld | input | 3 | Special pool result writes |
| spr_wb_data | input | 3x32 | Special pool result values |
| spr_lk_rdy | output | 3 | Special pool entry ready |
| spr_lk_data | output | 3x32 | Special pool entry value |
| spr_commit_req | input | 3 | Special pool retire requests |
| spr_commit_done | output | 3 | Special pool retirement performed |
| spr_arch_data | output | 3x32 | Special architected registers |

## Verification
The bench fills the integer pool with paired requests until it runs out and then tries one more. A pool whose capacity check is off would grant a seventh entry and overwrite a live one. It also retires one entry while paired requests arrive, so that exactly one of them is granted. The bench runs enough single allocations to wrap the tags from 5 back to 0. A wrong wrap would give out a tag outside the range or repeat a live one. Further cases are a commit while the head is not ready, which a careless design would retire early, and a flush in the same cycle as a commit, which a wrong priority would lose. The bench also writes a result to a tag that is not live and to tags past the end; a design without a liveness guard would leave a stale ready bit behind.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  localparam int NARCH     = 32;
  localparam int GPR_DEPTH = 6;
  localparam int FPR_DEPTH = 6;
  localparam int GPR_W     = 32;
  localparam int FPR_W     = 64;
  localparam int SPR_W     = 32;
  localparam int NSPR      = 3;
  localparam int NSLOT     = 2;
  localparam int NLOOK     = 2;
  localparam int ARCH_AW   = $clog2(NARCH);
  localparam int GPR_TW    = $clog2(GPR_DEPTH);
  localparam int FPR_TW    = $clog2(FPR_DEPTH);

  // advance a ring pointer by inc places (inc never exceeds depth)
  function automatic int ring_add(input int ptr, input int inc, input int depth);
    int sum;
    sum = ptr + inc;
    return (sum >= depth) ? sum - depth : sum;
  endfunction
endpackage

// File: rtl/rnm_alloc.sv
module rnm_alloc import rnm_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int NSL   = 2,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                    flush,
  input  logic [NSL-1:0]          req,
  input  logic [TW-1:0]           tail,
  input  logic [CW-1:0]           count,
  output logic [NSL-1:0]          gnt,
  output logic [NSL-1:0][TW-1:0]  tag,
  output logic [CW-1:0]           n_gnt
);
  // slots are served oldest first; a refused slot leaves no room for younger ones
  always_comb begin
    int used;
    used = 0;
    for (int s = 0; s < NSL; s++) begin
      tag[s] = TW'(ring_add(int'(tail), used, DEPTH));
      gnt[s] = 1'b0;
      if (req[s] && !flush && (int'(count) + used < DEPTH)) begin
        gnt[s] = 1'b1;
        used   = used + 1;
      end
    end
    n_gnt = CW'(used);
  end
endmodule

// File: rtl/rnm_lookup.sv
module rnm_lookup #(
  parameter int DEPTH = 6,
  parameter int DW    = 32,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [TW-1:0]    tag,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] rdy,
  input  logic [DW-1:0]    dat [DEPTH],
  input  logic             wb_hit,
  input  logic [TW-1:0]    wb_tag,
  input  logic [DW-1:0]    wb_data,
  output logic             rdy_o,
  output logic [DW-1:0]    data_o
);
  logic in_range, live, bypass;

  always_comb begin
    in_range = int'(tag) < DEPTH;
    live     = in_range && vld[tag];
    bypass   = live && wb_hit && (wb_tag == tag);
    rdy_o    = live && (rdy[tag] || bypass);
    if (bypass)        data_o = wb_data;
    else if (in_range) data_o = dat[tag];
    else               data_o = '0;
  end
endmodule

// File: rtl/rnm_pool.sv
module rnm_pool import rnm_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int DW    = 32,
  parameter int NA    = 32,
  parameter int NSL   = 2,
  parameter int NLK   = 2,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int AW   = (NA > 1) ? $clog2(NA) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [NSL-1:0]          alloc_req,
  input  logic [NSL-1:0][AW-1:0]  alloc_dst,
  output logic [NSL-1:0]          alloc_gnt,
  output logic [NSL-1:0][TW-1:0]  alloc_tag,
  input  logic                    wb_vld,
  input  logic [TW-1:0]           wb_tag,
  input  logic [DW-1:0]           wb_data,
  input  logic [NLK-1:0][TW-1:0]  lk_tag,
  output logic [NLK-1:0]          lk_rdy,
  output logic [NLK-1:0][DW-1:0]  lk_data,
  input  logic                    commit_req,
  output logic                    commit_done,
  input  logic [AW-1:0]           arch_idx,
  output logic [DW-1:0]           arch_data
);
  logic [DEPTH-1:0] vld_q, rdy_q;
  logic [AW-1:0]    dst_q  [DEPTH];
  logic [DW-1:0]    dat_q  [DEPTH];
  logic [DW-1:0]    arch_q [NA];
  logic [TW-1:0]    head_q, tail_q, head_nxt;
  logic [CW-1:0]    cnt_q, n_gnt;

  // named internal events
  logic wb_hit;
  logic pool_empty;

  rnm_alloc #(.DEPTH(DEPTH), .NSL(NSL)) u_alloc (
    .flush (flush),
    .req   (alloc_req),
    .tail  (tail_q),
    .count (cnt_q),
    .gnt   (alloc_gnt),
    .tag   (alloc_tag),
    .n_gnt (n_gnt)
  );

  always_comb begin
    pool_empty  = (cnt_q == '0);
    wb_hit      = wb_vld && (int'(wb_tag) < DEPTH) && vld_q[wb_tag];
    commit_done = commit_req && !pool_empty && rdy_q[head_q];
    head_nxt    = commit_done ? TW'(ring_add(int'(head_q), 1, DEPTH)) : head_q;
    arch_data   = (int'(arch_idx) < NA) ? arch_q[arch_idx] : '0;
  end

  for (genvar l = 0; l < NLK; l++) begin : g_look
    rnm_lookup #(.DEPTH(DEPTH), .DW(DW)) u_look (
      .tag     (lk_tag[l]),
      .vld     (vld_q),
      .rdy     (rdy_q),
      .dat     (dat_q),
      .wb_hit  (wb_hit),
      .wb_tag  (wb_tag),
      .wb_data (wb_data),
      .rdy_o   (lk_rdy[l]),
      .data_o  (lk_data[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dst_q[i] <= '0;
        dat_q[i] <= '0;
      end
      for (int r = 0; r < NA; r++) arch_q[r] <= '0;
    end else begin
      if (wb_hit) begin
        dat_q[wb_tag] <= wb_data;
        rdy_q[wb_tag] <= 1'b1;
      end
      if (commit_done) begin
        arch_q[dst_q[head_q]] <= dat_q[head_q];
        vld_q[head_q]         <= 1'b0;
        rdy_q[head_q]         <= 1'b0;
      end
      head_q <= head_nxt;
      if (flush) begin
        vld_q  <= '0;
        rdy_q  <= '0;
        tail_q <= head_nxt;
        cnt_q  <= '0;
      end else begin
        for (int s = 0; s < NSL; s++) begin
          if (alloc_gnt[s]) begin
            vld_q[alloc_tag[s]] <= 1'b1;
            rdy_q[alloc_tag[s]] <= 1'b0;
            dst_q[alloc_tag[s]] <= alloc_dst[s];
          end
        end
        tail_q <= TW'(ring_add(int'(tail_q), int'(n_gnt), DEPTH));
        cnt_q  <= cnt_q + n_gnt - CW'(commit_done);
      end
    end
  end

  // occupancy never exceeds the pool size
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  // a refused older slot blocks every younger slot
  assert_grant_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req[0] && !alloc_gnt[0]) |-> (alloc_gnt == '0));

  // an entry just handed out is not yet ready
  assert_fresh_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt[0] |=> !rdy_q[$past(alloc_tag[0])]);

  // retirement removes exactly one entry when nothing else changes occupancy
  assert_commit_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_done && !flush && alloc_gnt == '0) |=> int'(cnt_q) == int'($past(cnt_q)) - 1);

  // a flush empties the pool
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> pool_empty);

  // nothing is granted while squashing
  assert_no_grant_on_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (alloc_gnt == '0));
endmodule

// File: rtl/rename_pool_top.sv
module rename_pool_top import rnm_pkg::*; (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic [NSLOT-1:0]                gpr_alloc_req,
  input  logic [NSLOT-1:0][ARCH_AW-1:0]   gpr_alloc_dst,
  output logic [NSLOT-1:0]                gpr_alloc_gnt,
  output logic [NSLOT-1:0][GPR_TW-1:0]    gpr_alloc_tag,
  input  logic                            gpr_wb_vld,
  input  logic [GPR_TW-1:0]               gpr_wb_tag,
  input  logic [GPR_W-1:0]                gpr_wb_data,
  input  logic [NLOOK-1:0][GPR_TW-1:0]    gpr_lk_tag,
  output logic [NLOOK-1:0]                gpr_lk_rdy,
  output logic [NLOOK-1:0][GPR_W-1:0]     gpr_lk_data,
  input  logic                            gpr_commit_req,
  output logic                            gpr_commit_done,
  input  logic [ARCH_AW-1:0]              gpr_arch_idx,
  output logic [GPR_W-1:0]                gpr_arch_data,
  input  logic [NSLOT-1:0]                fpr_alloc_req,
  input  logic [NSLOT-1:0][ARCH_AW-1:0]   fpr_alloc_dst,
  output logic [NSLOT-1:0]                fpr_alloc_gnt,
  output logic [NSLOT-1:0][FPR_TW-1:0]    fpr_alloc_tag,
  input  logic                            fpr_wb_vld,
  input  logic [FPR_TW-1:0]               fpr_wb_tag,
  input  logic [FPR_W-1:0]                fpr_wb_data,
  input  logic [NLOOK-1:0][FPR_TW-1:0]    fpr_lk_tag,
  output logic [NLOOK-1:0]                fpr_lk_rdy,
  output logic [NLOOK-1:0][FPR_W-1:0]     fpr_lk_data,
  input  logic                            fpr_commit_req,
  output logic                            fpr_commit_done,
  input  logic [ARCH_AW-1:0]              fpr_arch_idx,
  output logic [FPR_W-1:0]                fpr_arch_data,
  input  logic [NSPR-1:0]                 spr_alloc_req,
  output logic [NSPR-1:0]                 spr_alloc_gnt,
  input  logic [NSPR-1:0]                 spr_wb_vld,
  input  logic [NSPR-1:0][SPR_W-1:0]      spr_wb_data,
  output logic [NSPR-1:0]                 spr_lk_rdy,
  output logic [NSPR-1:0][SPR_W-1:0]      spr_lk_data,
  input  logic [NSPR-1:0]                 spr_commit_req,
  output logic [NSPR-1:0]                 spr_commit_done,
  output logic [NSPR-1:0][SPR_W-1:0]      spr_arch_data
);
  rnm_pool #(.DEPTH(GPR_DEPTH), .DW(GPR_W), .NA(NARCH), .NSL(NSLOT), .NLK(NLOOK)) u_gpr (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_req(gpr_alloc_req), .alloc_dst(gpr_alloc_dst),
    .alloc_gnt(gpr_alloc_gnt), .alloc_tag(gpr_alloc_tag),
    .wb_vld(gpr_wb_vld), .wb_tag(gpr_wb_tag), .wb_data(gpr_wb_data),
    .lk_tag(gpr_lk_tag), .lk_rdy(gpr_lk_rdy), .lk_data(gpr_lk_data),
    .commit_req(gpr_commit_req), .commit_done(gpr_commit_done),
    .arch_idx(gpr_arch_idx), .arch_data(gpr_arch_data)
  );

  rnm_pool #(.DEPTH(FPR_DEPTH), .DW(FPR_W), .NA(NARCH), .NSL(NSLOT), .NLK(NLOOK)) u_fpr (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_req(fpr_alloc_req), .alloc_dst(fpr_alloc_dst),
    .alloc_gnt(fpr_alloc_gnt), .alloc_tag(fpr_alloc_tag),
    .wb_vld(fpr_wb_vld), .wb_tag(fpr_wb_tag), .wb_data(fpr_wb_data),
    .lk_tag(fpr_lk_tag), .lk_rdy(fpr_lk_rdy), .lk_data(fpr_lk_data),
    .commit_req(fpr_commit_req), .commit_done(fpr_commit_done),
    .arch_idx(fpr_arch_idx), .arch_data(fpr_arch_data)
  );

  // one single-entry pool per special register: bit 0 condition, 1 link, 2 count
  for (genvar g = 0; g < NSPR; g++) begin : g_spr
    logic [0:0] spr_tag_unused;
    rnm_pool #(.DEPTH(1), .DW(SPR_W), .NA(1), .NSL(1), .NLK(1)) u_spr (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc_req(spr_alloc_req[g]), .alloc_dst(1'b0),
      .alloc_gnt(spr_alloc_gnt[g]), .alloc_tag(spr_tag_unused),
      .wb_vld(spr_wb_vld[g]), .wb_tag(1'b0), .wb_data(spr_wb_data[g]),
      .lk_tag(1'b0), .lk_rdy(spr_lk_rdy[g]), .lk_data(spr_lk_data[g]),
      .commit_req(spr_commit_req[g]), .commit_done(spr_commit_done[g]),
      .arch_idx(1'b0), .arch_data(spr_arch_data[g])
    );
  end
endmodule

// File: tb/test_rename_pool_top.sv
`timescale 1ns/1ps
module test_rename_pool_top;
  logic clk = 1'b0;
  logic rst_n;
  logic flush;
  logic [1:0]        gpr_alloc_req;
  logic [1:0][4:0]   gpr_alloc_dst;
  logic [1:0]        gpr_alloc_gnt;
  logic [1:0][2:0]   gpr_alloc_tag;
  logic              gpr_wb_vld;
  logic [2:0]        gpr_wb_tag;
  logic [31:0]       gpr_wb_data;
  logic [1:0][2:0]   gpr_lk_tag;
  logic [1:0]        gpr_lk_rdy;
  logic [1:0][31:0]  gpr_lk_data;
  logic              gpr_commit_req, gpr_commit_done;
  logic [4:0]        gpr_arch_idx;
  logic [31:0]       gpr_arch_data;
  logic [1:0]        fpr_alloc_req;
  logic [1:0][4:0]   fpr_alloc_dst;
  logic [1:0]        fpr_alloc_gnt;
  logic [1:0][2:0]   fpr_alloc_tag;
  logic              fpr_wb_vld;
  logic [2:0]        fpr_wb_tag;
  logic [63:0]       fpr_wb_data;
  logic [1:0][2:0]   fpr_lk_tag;
  logic [1:0]        fpr_lk_rdy;
  logic [1:0][63:0]  fpr_lk_data;
  logic              fpr_commit_req, fpr_commit_done;
  logic [4:0]        fpr_arch_idx;
  logic [63:0]       fpr_arch_data;
  logic [2:0]        spr_alloc_req, spr_alloc_gnt, spr_wb_vld, spr_lk_rdy;
  logic [2:0][31:0]  spr_wb_data, spr_lk_data, spr_arch_data;
  logic [2:0]        spr_commit_req, spr_commit_done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rename_pool_top i_rename_pool_top (.*);

  // dst (5 bits) and 64-bit result; integer pool uses the low half
  localparam logic [68:0] VEC [8] = '{
    {5'd1,  64'h0123_4567_89AB_CDEF},
    {5'd2,  64'hFFFF_FFFF_FFFF_FFFF},
    {5'd3,  64'h0000_0000_0000_0001},
    {5'd4,  64'h8000_0000_8000_0000},
    {5'd5,  64'hDEAD_BEEF_CAFE_F00D},
    {5'd6,  64'h5555_AAAA_5555_AAAA},
    {5'd7,  64'h1357_9BDF_2468_ACE0},
    {5'd31, 64'h0F0F_0F0F_F0F0_F0F0}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0;
    gpr_alloc_req = '0; gpr_alloc_dst = '0; gpr_wb_vld = 0; gpr_wb_tag = '0; gpr_wb_data = '0;
    gpr_lk_tag = '0; gpr_commit_req = 0; gpr_arch_idx = '0;
    fpr_alloc_req = '0; fpr_alloc_dst = '0; fpr_wb_vld = 0; fpr_wb_tag = '0; fpr_wb_data = '0;
    fpr_lk_tag = '0; fpr_commit_req = 0; fpr_arch_idx = '0;
    spr_alloc_req = '0; spr_wb_vld = '0; spr_wb_data = '0; spr_commit_req = '0;
  endtask

  // advance one edge, then allow a moment before new drive
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_tag;
    idle();
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;

    // R1 reset state
    gpr_commit_req = 1; fpr_commit_req = 1; spr_commit_req = 3'b111;
    gpr_lk_tag[0] = 3'd0; gpr_arch_idx = 5'd7; fpr_arch_idx = 5'd31;
    #1;
    chk("R1", "gpr commit after reset", 64'(gpr_commit_done), 64'd0);
    chk("R1", "fpr commit after reset", 64'(fpr_commit_done), 64'd0);
    chk("R1", "spr commit after reset", 64'(spr_commit_done), 64'd0);
    chk("R1", "gpr lookup ready", 64'(gpr_lk_rdy[0]), 64'd0);
    chk("R1", "gpr arch zero", 64'(gpr_arch_data), 64'd0);
    chk("R1", "fpr arch zero", fpr_arch_data, 64'd0);
    chk("R1", "spr arch zero", 64'(spr_arch_data[2]), 64'd0);
    idle();
    cyc();

    // vector walk: allocate, write, commit, read back; tags wrap through 0
    exp_tag = 0;
    for (int i = 0; i < 8; i++) begin
      logic [4:0]  d;
      logic [63:0] v;
      d = VEC[i][68:64];
      v = VEC[i][63:0];
      gpr_alloc_req = 2'b01; gpr_alloc_dst[0] = d;
      fpr_alloc_req = 2'b01; fpr_alloc_dst[0] = d;
      #1;
      chk("R3", "gpr tag order", 64'(gpr_alloc_tag[0]), 64'(exp_tag));
      chk("R3", "fpr tag order", 64'(fpr_alloc_tag[0]), 64'(exp_tag));
      cyc();
      idle();
      gpr_lk_tag[1] = 3'(exp_tag); fpr_lk_tag[1] = 3'(exp_tag);
      #1;
      chk("R5", "gpr fresh entry not ready", 64'(gpr_lk_rdy[1]), 64'd0);
      gpr_wb_vld = 1; gpr_wb_tag = 3'(exp_tag); gpr_wb_data = v[31:0];
      fpr_wb_vld = 1; fpr_wb_tag = 3'(exp_tag); fpr_wb_data = v;
      #1;
      chk("R4", "gpr bypass ready", 64'(gpr_lk_rdy[1]), 64'd1);
      chk("R4", "gpr bypass data", 64'(gpr_lk_data[1]), 64'(v[31:0]));
      chk("R4", "fpr bypass data", fpr_lk_data[1], v);
      cyc();
      gpr_wb_vld = 0; fpr_wb_vld = 0;
      gpr_commit_req = 1; fpr_commit_req = 1;
      #1;
      chk("R4", "fpr stored ready", 64'(fpr_lk_rdy[1]), 64'd1);
      chk("R6", "gpr commit done", 64'(gpr_commit_done), 64'd1);
      cyc();
      idle();
      gpr_arch_idx = d; fpr_arch_idx = d;
      #1;
      chk("R6", "gpr arch value", 64'(gpr_arch_data), 64'(v[31:0]));
      chk("R6", "fpr arch value", fpr_arch_data, v);
      exp_tag = (exp_tag + 1) % 6;
    end
    idle();
    cyc();

    // R2/R3 fill the integer pool with pairs; head = tail = 2
    for (int p = 0; p < 3; p++) begin
      gpr_alloc_req = 2'b11;
      gpr_alloc_dst[0] = 5'(20 + 2*p); gpr_alloc_dst[1] = 5'(21 + 2*p);
      #1;
      chk("R3", "pair grant", 64'(gpr_alloc_gnt), 64'd3);
      chk("R3", "pair tag0", 64'(gpr_alloc_tag[0]), 64'((2 + 2*p) % 6));
      chk("R3", "pair tag1", 64'(gpr_alloc_tag[1]), 64'((3 + 2*p) % 6));
      cyc();
    end
    gpr_alloc_req = 2'b11;
    #1;
    chk("R2", "full pool refuses", 64'(gpr_alloc_gnt), 64'd0);
    idle();
    gpr_commit_req = 1;
    #1;
    chk("R6", "head not ready no commit", 64'(gpr_commit_done), 64'd0);
    idle();
    gpr_wb_vld = 1; gpr_wb_tag = 3'd2; gpr_wb_data = 32'hAAAA_0002;
    cyc();
    idle();
    gpr_commit_req = 1; gpr_alloc_req = 2'b11; gpr_alloc_dst = '0;
    #1;
    chk("R6", "commit when head ready", 64'(gpr_commit_done), 64'd1);
    chk("R2", "freed entry not reused same cycle", 64'(gpr_alloc_gnt), 64'd0);
    cyc();
    idle();
    gpr_arch_idx = 5'd20; gpr_alloc_req = 2'b11; gpr_alloc_dst[0] = 5'd26;
    #1;
    chk("R6", "committed arch value", 64'(gpr_arch_data), 64'hAAAA_0002);
    chk("R3", "one free slot grants older only", 64'(gpr_alloc_gnt), 64'd1);
    chk("R3", "wrapped tag", 64'(gpr_alloc_tag[0]), 64'd2);
    cyc();

    // R7 flush: write tag 3 first, then squash
    idle();
    gpr_wb_vld = 1; gpr_wb_tag = 3'd3; gpr_wb_data = 32'hBBBB_0003;
    cyc();
    idle();
    flush = 1; gpr_alloc_req = 2'b11; fpr_alloc_req = 2'b01;
    #1;
    chk("R7", "no gpr grant in flush", 64'(gpr_alloc_gnt), 64'd0);
    chk("R7", "no fpr grant in flush", 64'(fpr_alloc_gnt), 64'd0);
    cyc();
    idle();
    gpr_lk_tag[0] = 3'd3; gpr_arch_idx = 5'd21;
    #1;
    chk("R7", "flushed entry not ready", 64'(gpr_lk_rdy[0]), 64'd0);
    chk("R7", "arch untouched by flush", 64'(gpr_arch_data), 64'd0);
    gpr_alloc_req = 2'b10; gpr_alloc_dst[1] = 5'd27;
    #1;
    chk("R7", "younger slot alone granted", 64'(gpr_alloc_gnt), 64'd2);
    chk("R7", "restart at head tag", 64'(gpr_alloc_tag[1]), 64'd3);
    cyc();

    // R8 commit together with flush
    idle();
    gpr_wb_vld = 1; gpr_wb_tag = 3'd3; gpr_wb_data = 32'hCCCC_0003;
    cyc();
    idle();
    gpr_commit_req = 1; flush = 1;
    #1;
    chk("R8", "commit honoured during flush", 64'(gpr_commit_done), 64'd1);
    cyc();
    idle();
    gpr_arch_idx = 5'd27; gpr_alloc_req = 2'b01;
    #1;
    chk("R8", "arch written during flush", 64'(gpr_arch_data), 64'hCCCC_0003);
    chk("R8", "next tag after retired", 64'(gpr_alloc_tag[0]), 64'd4);
    cyc();
    idle();
    flush = 1;
    cyc();

    // R9 write to a tag that is not live
    idle();
    gpr_wb_vld = 1; gpr_wb_tag = 3'd0; gpr_wb_data = 32'h1234_5678;
    cyc();
    gpr_wb_tag = 3'd7;
    cyc();
    idle();
    gpr_alloc_req = 2'b01;
    gpr_lk_tag[0] = 3'd0;
    #1;
    chk("R9", "stale write left no ready", 64'(gpr_lk_rdy[0]), 64'd0);
    chk("R9", "pool head unchanged", 64'(gpr_alloc_tag[0]), 64'd4);
    cyc();
    idle();
    gpr_lk_tag[0] = 3'd4;
    #1;
    chk("R9", "live entry still not ready", 64'(gpr_lk_rdy[0]), 64'd0);
    flush = 1;
    cyc();

    // R10 special pools
    idle();
    spr_alloc_req = 3'b011;
    #1;
    chk("R10", "condition and link granted", 64'(spr_alloc_gnt), 64'd3);
    cyc();
    idle();
    spr_alloc_req = 3'b101;
    spr_wb_vld = 3'b001; spr_wb_data[0] = 32'h0000_0011;
    #1;
    chk("R2", "one-entry pool refuses second", 64'(spr_alloc_gnt), 64'd4);
    chk("R10", "condition bypass", 64'(spr_lk_rdy), 64'd1);
    chk("R10", "condition data", 64'(spr_lk_data[0]), 64'h11);
    cyc();
    idle();
    spr_commit_req = 3'b011;
    #1;
    chk("R10", "only ready pool retires", 64'(spr_commit_done), 64'd1);
    cyc();
    idle();
    #1;
    chk("R10", "condition arch", 64'(spr_arch_data[0]), 64'h11);
    chk("R10", "link arch untouched", 64'(spr_arch_data[1]), 64'd0);
    chk("R10", "count arch untouched", 64'(spr_arch_data[2]), 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule